// File: doc/BRIEF.md
# Coherent Master Acknowledge Generator

This block sits on the master side of a coherent AXI-style port and looks after the two response channels that flow back into the master. On the read data channel it drives the ready signal from a local stall input. When the final beat of a read burst is accepted, it sends a read acknowledge pulse one clock later. On the write response channel it keeps the ready signal high from the first cycle after reset. Each accepted write response is answered with a write acknowledge pulse one clock later.

The block also watches the write address channel. It keeps a count of write addresses that have been accepted and not yet answered. A write response that turns up while this count is zero is a protocol breach by the slave side. The block raises a sticky error flag for it, together with a one-cycle error pulse.

A mode input selects the coherent interface or the AXI3 compatibility mode. Both acknowledges are generated in either mode. Read-data back-pressure follows the usual valid/ready rule: a beat transfers on a clock edge where both valid and ready are high. Ready may fall at any time, including between beats of the same burst. The write response ready never falls once reset is over, so responses are never held off.

Top module: `coh_ack_gen`

## Requirements
- R1: `rready` equals the inverse of `rd_stall` from the first cycle after reset release, with no regard to burst position, so it may fall between beats of one burst. `rready` is low while reset is asserted and in the first cycle after.
- R2: `rack` is high in the cycle that follows a clock edge where `rvalid`, `rready` and `rlast` were all high, and low after every other edge. A handshake on a beat that is not the last gives no pulse.
- R3: Both acknowledges behave the same whether `compat_mode` is 0 (coherent interface) or 1 (AXI3 compatibility).
- R4: `bready` is low during reset, rises in the cycle after the first clock edge at which `rst_n` is sampled high, and then stays high until the next reset.
- R5: `wack` is high in the cycle that follows a clock edge where `bvalid` and `bready` were both high, and low otherwise.
- R6: Completions on consecutive cycles give acknowledge pulses on consecutive cycles. Each handshake gives exactly one pulse, with none merged or dropped.
- R7: `aw_pending` goes up by one on each edge with `awvalid` and `awready` high, and down by one on each write response handshake. When both happen on the same edge it does not change. It saturates at `PEND_MAX`. A response handshake at zero does not decrement it, so a simultaneous address at zero leaves it at 1.
- R8: If `bvalid` is high on an edge while `aw_pending` is zero, `orphan_pulse` is high for exactly the next cycle. `orphan_err` goes high in that same cycle and stays high until reset.
- R9: A synchronous active-low `rst_n` clears `rack`, `wack`, `aw_pending`, `orphan_err`, `orphan_pulse` and `bready` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| compat_mode | input | 1 | 0 = coherent interface, 1 = AXI3 compatibility |
| rd_stall | input | 1 | Local request to hold off read data |
| rvalid | input | 1 | Read data beat valid |
| rlast | input | 1 | Beat is the last of its burst |
| rready | output | 1 | Read data ready |
| rack | output | 1 | Read acknowledge pulse |
| awvalid | input | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| wack | output | 1 | Write acknowledge pulse |
| aw_pending | output | $clog2(PEND_MAX+1) | Accepted write addresses still awaiting a response |
| orphan_err | output | 1 | Sticky flag: response seen with nothing pending |
| orphan_pulse | output | 1 | One-cycle pulse per orphan response |

## Verification
Two kinds of event can land on the same edge. A write address handshake and a write response handshake can coincide, which moves the pending count up and down at once. That overlap is most telling at the saturation limit and at zero, where the response is also an orphan. A read completion and a write response can also coincide, giving both acknowledges in one cycle. The bench makes these overlaps happen by sweeping every ordered pair of the 128 input combinations with a small limit. It then steers the count to its limit and back down to zero with directed sequences. Every port is compared each cycle against an arithmetic model that updates the count by the R7 and R8 rules.

// File: rtl/coh_ack_pkg.sv
package coh_ack_pkg;

  typedef enum logic {
    LINK_COHERENT = 1'b0,
    LINK_AXI3     = 1'b1
  } link_mode_e;

  // Acknowledges are produced for every defined link mode.
  function automatic logic ack_allowed(input link_mode_e mode);
    return (mode == LINK_COHERENT) || (mode == LINK_AXI3);
  endfunction

endpackage

// File: rtl/coh_wr_ack.sv
module coh_wr_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_en,
  input  logic bvalid,
  output logic bready,
  output logic live,
  output logic wack
);

  logic live_q;
  logic wack_q;

  // Ready opens on the first cycle after reset and stays open.
  always_ff @(posedge clk) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wack_q <= 1'b0;
    else        wack_q <= ack_en & bvalid & live_q;
  end

  assign bready = live_q;
  assign live   = live_q;
  assign wack   = wack_q;

endmodule

// File: rtl/coh_rd_ack.sv
module coh_rd_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic ack_en,
  input  logic rd_stall,
  input  logic rvalid,
  input  logic rlast,
  output logic rready,
  output logic rack
);

  logic ready_c;
  logic last_hs;
  logic rack_q;

  assign ready_c = live & ~rd_stall;
  assign last_hs = rvalid & ready_c & rlast;

  always_ff @(posedge clk) begin
    if (!rst_n) rack_q <= 1'b0;
    else        rack_q <= ack_en & last_hs;
  end

  assign rready = ready_c;
  assign rack   = rack_q;

endmodule

// File: rtl/coh_aw_tracker.sv
module coh_aw_tracker #(
  parameter int PEND_MAX = 15,
  localparam int CNT_W   = $clog2(PEND_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aw_hs,
  input  logic             b_hs,
  input  logic             bvalid,
  output logic [CNT_W-1:0] pending,
  output logic             err_flag,
  output logic             err_pulse
);

  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(PEND_MAX);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_zero;
  logic             at_top;
  logic             inc;
  logic             dec;
  logic             orphan;
  logic             flag_q;
  logic             pulse_q;

  assign at_zero = (cnt_q == CNT_ZERO);
  assign at_top  = (cnt_q == CNT_TOP);
  assign dec     = b_hs & ~at_zero;
  assign inc     = aw_hs & (~at_top | dec);
  assign orphan  = bvalid & at_zero;

  always_comb begin
    cnt_d = cnt_q;
    unique case ({inc, dec})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      flag_q  <= flag_q | orphan;
      pulse_q <= orphan;
    end
  end

  assign pending   = cnt_q;
  assign err_flag  = flag_q;
  assign err_pulse = pulse_q;

endmodule

// File: rtl/coh_ack_gen.sv
module coh_ack_gen #(
  parameter int PEND_MAX = 15,
  localparam int CNT_W   = $clog2(PEND_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             compat_mode,
  input  logic             rd_stall,
  input  logic             rvalid,
  input  logic             rlast,
  output logic             rready,
  output logic             rack,
  input  logic             awvalid,
  input  logic             awready,
  input  logic             bvalid,
  output logic             bready,
  output logic             wack,
  output logic [CNT_W-1:0] aw_pending,
  output logic             orphan_err,
  output logic             orphan_pulse
);
  import coh_ack_pkg::*;

  link_mode_e mode;
  logic       ack_en;
  logic       live;
  logic       b_hs;
  logic       aw_hs;

  assign mode   = link_mode_e'(compat_mode);
  assign ack_en = ack_allowed(mode);
  assign b_hs   = bvalid & bready;
  assign aw_hs  = awvalid & awready;

  coh_wr_ack u_wr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ack_en (ack_en),
    .bvalid (bvalid),
    .bready (bready),
    .live   (live),
    .wack   (wack)
  );

  coh_rd_ack u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .live     (live),
    .ack_en   (ack_en),
    .rd_stall (rd_stall),
    .rvalid   (rvalid),
    .rlast    (rlast),
    .rready   (rready),
    .rack     (rack)
  );

  coh_aw_tracker #(.PEND_MAX(PEND_MAX)) u_aw (
    .clk       (clk),
    .rst_n     (rst_n),
    .aw_hs     (aw_hs),
    .b_hs      (b_hs),
    .bvalid    (bvalid),
    .pending   (aw_pending),
    .err_flag  (orphan_err),
    .err_pulse (orphan_pulse)
  );

endmodule

// File: rtl/coh_ack_gen_chk.sv
module coh_ack_gen_chk #(
  parameter int PEND_MAX = 15,
  localparam int CNT_W   = $clog2(PEND_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             compat_mode,
  input logic             rd_stall,
  input logic             rvalid,
  input logic             rlast,
  input logic             rready,
  input logic             rack,
  input logic             bvalid,
  input logic             bready,
  input logic             wack,
  input logic [CNT_W-1:0] aw_pending,
  input logic             orphan_err,
  input logic             orphan_pulse
);

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) rd_stall |-> !rready); // R1
  AST_RACK_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n) (rvalid && rready && rlast) |=> rack); // R2
  AST_RACK_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n) !(rvalid && rready && rlast) |=> !rack); // R2
  AST_RACK_COMPAT: assert property (@(posedge clk) disable iff (!rst_n) (compat_mode && rvalid && rready && rlast) |=> rack); // R3
  AST_WACK_COMPAT: assert property (@(posedge clk) disable iff (!rst_n) (compat_mode && bvalid && bready) |=> wack); // R3
  AST_BREADY_HELD: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> bready); // R4
  AST_WACK_ON_B: assert property (@(posedge clk) disable iff (!rst_n) (bvalid && bready) |=> wack); // R5
  AST_WACK_ONLY_B: assert property (@(posedge clk) disable iff (!rst_n) !(bvalid && bready) |=> !wack); // R5
  AST_PEND_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) aw_pending <= CNT_W'(PEND_MAX)); // R7
  AST_ORPHAN_RAISE: assert property (@(posedge clk) disable iff (!rst_n) (bvalid && aw_pending == '0) |=> (orphan_pulse && orphan_err)); // R8
  AST_ORPHAN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) orphan_err |=> orphan_err); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!rack && !wack && !bready && aw_pending == '0 && !orphan_err && !orphan_pulse)); // R9

endmodule

bind coh_ack_gen coh_ack_gen_chk #(.PEND_MAX(PEND_MAX)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .compat_mode  (compat_mode),
  .rd_stall     (rd_stall),
  .rvalid       (rvalid),
  .rlast        (rlast),
  .rready       (rready),
  .rack         (rack),
  .bvalid       (bvalid),
  .bready       (bready),
  .wack         (wack),
  .aw_pending   (aw_pending),
  .orphan_err   (orphan_err),
  .orphan_pulse (orphan_pulse)
);

// File: tb/test_coh_ack_gen.sv
`timescale 1ns/1ps
module test_coh_ack_gen;

  localparam int PMAX = 3;
  localparam int CW   = $clog2(PMAX + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          compat_mode = 1'b0;
  logic          rd_stall = 1'b0;
  logic          rvalid = 1'b0;
  logic          rlast = 1'b0;
  logic          awvalid = 1'b0;
  logic          awready = 1'b0;
  logic          bvalid = 1'b0;
  logic          rready;
  logic          rack;
  logic          bready;
  logic          wack;
  logic [CW-1:0] aw_pending;
  logic          orphan_err;
  logic          orphan_pulse;

  always #2 clk = ~clk;

  coh_ack_gen #(.PEND_MAX(PMAX)) i_coh_ack_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .compat_mode  (compat_mode),
    .rd_stall     (rd_stall),
    .rvalid       (rvalid),
    .rlast        (rlast),
    .rready       (rready),
    .rack         (rack),
    .awvalid      (awvalid),
    .awready      (awready),
    .bvalid       (bvalid),
    .bready       (bready),
    .wack         (wack),
    .aw_pending   (aw_pending),
    .orphan_err   (orphan_err),
    .orphan_pulse (orphan_pulse)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // model state
  logic m_live = 1'b0, m_rack = 1'b0, m_wack = 1'b0, m_err = 1'b0, m_pulse = 1'b0;
  int   m_cnt = 0;

  task automatic chk(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // v: bit0 rd_stall, bit1 rvalid, bit2 rlast, bit3 bvalid, bit4 awvalid, bit5 awready, bit6 compat_mode
  task automatic step(input logic rst, input logic [6:0] v);
    logic e_rready, hs_r, hs_b, aw, n_rack, n_wack, n_pulse, n_err, n_live, inc, dec;
    int   n_cnt;
    string rtag, wtag;
    @(negedge clk);
    rst_n = rst;
    {compat_mode, awready, awvalid, bvalid, rlast, rvalid, rd_stall} = v;
    #1;
    e_rready = m_live & ~v[0];
    chk(int'(rready), int'(e_rready), "R1 rready");
    chk(int'(bready), int'(m_live), "R4 bready");
    hs_r = v[1] & e_rready & v[2];
    hs_b = v[3] & m_live;
    aw   = v[4] & v[5];
    if (!rst) begin
      n_rack = 0; n_wack = 0; n_pulse = 0; n_err = 0; n_live = 0; n_cnt = 0;
    end else begin
      n_live  = 1'b1;
      n_rack  = hs_r;
      n_wack  = hs_b;
      n_pulse = v[3] & (m_cnt == 0);
      n_err   = m_err | n_pulse;
      dec     = hs_b & (m_cnt != 0);
      inc     = aw & ((m_cnt != PMAX) | dec);
      n_cnt   = m_cnt + int'(inc) - int'(dec);
    end
    rtag = !rst ? "R9 rack" : (v[6] ? "R3 rack" : ((m_rack && n_rack) ? "R6 rack" : "R2 rack"));
    wtag = !rst ? "R9 wack" : (v[6] ? "R3 wack" : ((m_wack && n_wack) ? "R6 wack" : "R5 wack"));
    @(posedge clk);
    #1;
    m_live = n_live; m_rack = n_rack; m_wack = n_wack;
    m_pulse = n_pulse; m_err = n_err; m_cnt = n_cnt;
    chk(int'(rack), int'(m_rack), rtag);
    chk(int'(wack), int'(m_wack), wtag);
    chk(int'(aw_pending), m_cnt, !rst ? "R9 aw_pending" : "R7 aw_pending");
    chk(int'(orphan_pulse), int'(m_pulse), "R8 orphan_pulse");
    chk(int'(orphan_err), int'(m_err), !rst ? "R9 orphan_err" : "R8 orphan_err");
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R9: reset state, with inputs active
    for (int i = 0; i < 3; i++) step(1'b0, 7'h3e);
    // R4: first cycle after release
    step(1'b1, 7'h00);
    step(1'b1, 7'h00);
    // R6: back-to-back last beats and responses
    for (int i = 0; i < 4; i++) step(1'b1, 7'b0001110);
    // R1: stall mid-burst
    step(1'b1, 7'b0000010);
    step(1'b1, 7'b0000011);
    step(1'b1, 7'b0000111);
    // R7: fill to saturation, then overlap at limit
    for (int i = 0; i < PMAX + 2; i++) step(1'b1, 7'b0110000);
    step(1'b1, 7'b0111000);
    step(1'b1, 7'b1111000);
    // R7/R8: drain past zero, then overlap at zero
    for (int i = 0; i < PMAX + 1; i++) step(1'b1, 7'b0001000);
    step(1'b1, 7'b0111000);
    // R9: mid-run reset clears sticky flag
    step(1'b0, 7'h00);
    step(1'b1, 7'h00);
    // R3 and all overlaps: every ordered pair of input combinations
    for (int a = 0; a < 128; a++) begin
      for (int b = 0; b < 128; b++) begin
        step(1'b1, 7'(a));
        step(1'b1, 7'(b));
      end
      if ((a % 16) == 15) step(1'b0, 7'(a));
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule